// File: doc/BRIEF.md
# Over-temperature alert controller

This block watches a stream of temperature results and decides when a single alert pad should be driven. Each result arrives as a 16-bit two's-complement word with the twelve meaningful bits left-justified in [15:4]; the low nibble is padding. Whenever a result strobe arrives, the word is compared as a signed number against a trip limit and a re-arm (hysteresis) limit, both in the same format. A fault is a result at or above the trip limit. A programmable number of faults in a row must be seen before the alert goes active.

Two alert behaviours are selectable. In comparator mode the alert clears itself once a result falls strictly below the re-arm limit. In interrupt mode the alert latches, whatever the temperature does, until the bus interface reports that any register was read. After such a clear, a fresh run of consecutive faults is needed before it fires again. The pad is modelled as an open-drain pull-down enable, and the polarity bit decides whether an active alert pulls the pad low or releases it. Sensing, conversion and the serial protocol live elsewhere. Shutdown is simply the absence of result strobes, and it leaves the alert as it was.

The control is a three-state machine. QUIET means the alert is inactive and no fault is pending. QUALIFY means the alert is inactive and some consecutive faults have been counted. ALERT means the alert is active. The named transitions are:
- arm: QUIET to QUALIFY on a fault when more than one is needed.
- trip: QUIET or QUALIFY to ALERT when the count is reached.
- break: QUALIFY to QUIET on a non-fault result or a configuration write.
- release: ALERT to QUIET, either on a below-re-arm result in comparator mode or on a bus read in interrupt mode.

Top module: `thermal_alert_ctrl`

## Requirements
- R1: While reset is held and after it, the alert is inactive: `alert_pad_drive` is 0 when `cfg_active_high` is 0 and 1 when it is 1.
- R2: A result is a fault when bits [15:4] of `sample_word`, taken as signed, are greater than or equal to bits [15:4] of `trip_limit`, taken as signed; bits [3:0] of every word are ignored.
- R3: `cfg_fault_sel` selects how many consecutive faults raise the alert: 2'b00 needs 1, 2'b01 needs 2, 2'b10 needs 4, 2'b11 needs 6. The alert is visible on the pad in the cycle after the clock edge that captures the final fault.
- R4: A non-fault result while faults are pending discards the count, so that faults separated by it do not add up.
- R5: In comparator mode (`cfg_interrupt` = 0) an active alert stays active until a result whose signed [15:4] is strictly below the re-arm limit arrives. A result equal to the re-arm limit keeps it active, and bus reads have no effect on it.
- R6: In interrupt mode (`cfg_interrupt` = 1) an active alert ignores all results and clears on the edge that captures `bus_read`. A read coinciding with the result that raises the alert does not cancel it.
- R7: After an interrupt-mode clear, the alert rises again only after a new full run of the selected number of consecutive faults.
- R8: Cycles without `sample_valid`, `bus_read` or `cfg_write` leave the alert and any pending count unchanged, so stopping conversions does not reset the output.
- R9: A `cfg_write` pulse discards any pending fault count, together with a result arriving in the same cycle, but does not clear an active alert.
- R10: The pad drive equals the alert state XOR `cfg_active_high`: with 0 an active alert pulls the pad low (drive 1), and with 1 an inactive alert does. A polarity change acts in the same cycle.
- R11: A bus read while no alert is active changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_valid | input | 1 | One-cycle strobe: a new temperature result is present |
| sample_word | input | 16 | Temperature result, signed, significant bits [15:4] |
| trip_limit | input | 16 | High limit word, same format |
| rearm_limit | input | 16 | Hysteresis limit word, same format |
| cfg_interrupt | input | 1 | 0 comparator mode, 1 interrupt mode |
| cfg_active_high | input | 1 | Pad polarity select |
| cfg_fault_sel | input | 2 | Consecutive fault count select |
| cfg_write | input | 1 | Strobe: mode or fault-count setting was written |
| bus_read | input | 1 | Strobe: some register was read over the bus |
| alert_pad_drive | output | 1 | Open-drain pull-down enable for the alert pad |

## Verification
The bench sweeps every fault-count setting in both modes and both polarities. It breaks each fault run one result short, where a counter that failed to restart on a non-fault result would trip early. It places a read in the same cycle as the raising result, where a design that ordered the read first would lose the interrupt. It presents results exactly equal to each limit and words with junk in the low nibble, where an off-by-one or an unsigned compare would trip or release on the wrong result. The negative limits are chosen so that an unsigned compare flips the outcome.

// File: rtl/thermal_alert_pkg.sv
package thermal_alert_pkg;

    typedef enum logic [1:0] {
        ST_QUIET    = 2'd0,
        ST_QUALIFY  = 2'd1,
        ST_ALERT    = 2'd2
    } alert_state_e;

    localparam int MAX_FAULTS = 6;
    localparam int CNT_W      = $clog2(MAX_FAULTS + 1);

    // Decode of the two-bit run-length select into a fault count.
    function automatic logic [CNT_W-1:0] faults_needed(input logic [1:0] sel);
        logic [CNT_W-1:0] n;
        unique case (sel)
            2'b00:   n = CNT_W'(1);
            2'b01:   n = CNT_W'(2);
            2'b10:   n = CNT_W'(4);
            default: n = CNT_W'(MAX_FAULTS);
        endcase
        return n;
    endfunction

endpackage

// File: rtl/ta_limit_compare.sv
module ta_limit_compare #(
    parameter int SIG_W = 12
) (
    input  logic [SIG_W-1:0] sample_sig,
    input  logic [SIG_W-1:0] trip_sig,
    input  logic [SIG_W-1:0] rearm_sig,
    output logic             at_or_above_trip,
    output logic             below_rearm
);

    always_comb begin
        at_or_above_trip = $signed(sample_sig) >= $signed(trip_sig);
        below_rearm      = $signed(sample_sig) <  $signed(rearm_sig);
    end

endmodule

// File: rtl/ta_alert_fsm.sv
module ta_alert_fsm
    import thermal_alert_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sample_valid,
    input  logic               is_fault,
    input  logic               below_rearm,
    input  logic               cfg_interrupt,
    input  logic [1:0]         cfg_fault_sel,
    input  logic               cfg_write,
    input  logic               bus_read,
    output alert_state_e       state_o,
    output logic [CNT_W-1:0]   fault_cnt_o,
    output logic               alert_active
);

    alert_state_e     state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W:0]   cnt_inc;
    logic [CNT_W-1:0] need;

    assign need    = faults_needed(cfg_fault_sel);
    assign cnt_inc = {1'b0, cnt_q} + (CNT_W+1)'(1);

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_QUIET;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Transitions.
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_QUIET: begin
                if (!cfg_write && sample_valid && is_fault) begin
                    if (need == CNT_W'(1)) begin
                        state_d = ST_ALERT;                  // trip
                    end else begin
                        state_d = ST_QUALIFY;                // arm
                        cnt_d   = CNT_W'(1);
                    end
                end
            end
            ST_QUALIFY: begin
                if (cfg_write) begin
                    state_d = ST_QUIET;                      // break
                    cnt_d   = '0;
                end else if (sample_valid) begin
                    if (!is_fault) begin
                        state_d = ST_QUIET;                  // break
                        cnt_d   = '0;
                    end else if (cnt_inc >= {1'b0, need}) begin
                        state_d = ST_ALERT;                  // trip
                        cnt_d   = '0;
                    end else begin
                        cnt_d   = cnt_inc[CNT_W-1:0];
                    end
                end
            end
            ST_ALERT: begin
                if (cfg_interrupt) begin
                    if (bus_read) begin
                        state_d = ST_QUIET;                  // release
                        cnt_d   = '0;
                    end
                end else if (sample_valid && below_rearm) begin
                    state_d = ST_QUIET;                      // release
                    cnt_d   = '0;
                end
            end
            default: begin
                state_d = ST_QUIET;
                cnt_d   = '0;
            end
        endcase
    end

    // Outputs.
    always_comb begin
        state_o      = state_q;
        fault_cnt_o  = cnt_q;
        alert_active = (state_q == ST_ALERT);
    end

endmodule

// File: rtl/ta_pad_driver.sv
module ta_pad_driver (
    input  logic alert_active,
    input  logic active_high,
    output logic pad_pulldown
);

    // Active-low: pull down while alerting. Active-high: pull down while idle.
    always_comb pad_pulldown = alert_active ^ active_high;

endmodule

// File: rtl/thermal_alert_ctrl.sv
module thermal_alert_ctrl
    import thermal_alert_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int FRAC_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_valid,
    input  logic [WORD_W-1:0] sample_word,
    input  logic [WORD_W-1:0] trip_limit,
    input  logic [WORD_W-1:0] rearm_limit,
    input  logic              cfg_interrupt,
    input  logic              cfg_active_high,
    input  logic [1:0]        cfg_fault_sel,
    input  logic              cfg_write,
    input  logic              bus_read,
    output logic              alert_pad_drive
);

    localparam int SIG_W = WORD_W - FRAC_W;

    logic             is_fault;
    logic             below_rearm;
    logic             alert_active;
    alert_state_e     state;
    logic [CNT_W-1:0] fault_cnt;
    logic             unused_frac;

    assign unused_frac = ^{sample_word[FRAC_W-1:0], trip_limit[FRAC_W-1:0],
                           rearm_limit[FRAC_W-1:0]};

    ta_limit_compare #(.SIG_W(SIG_W)) u_cmp (
        .sample_sig       (sample_word[WORD_W-1:FRAC_W]),
        .trip_sig         (trip_limit[WORD_W-1:FRAC_W]),
        .rearm_sig        (rearm_limit[WORD_W-1:FRAC_W]),
        .at_or_above_trip (is_fault),
        .below_rearm      (below_rearm)
    );

    ta_alert_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .sample_valid  (sample_valid),
        .is_fault      (is_fault),
        .below_rearm   (below_rearm),
        .cfg_interrupt (cfg_interrupt),
        .cfg_fault_sel (cfg_fault_sel),
        .cfg_write     (cfg_write),
        .bus_read      (bus_read),
        .state_o       (state),
        .fault_cnt_o   (fault_cnt),
        .alert_active  (alert_active)
    );

    ta_pad_driver u_pad (
        .alert_active (alert_active),
        .active_high  (cfg_active_high),
        .pad_pulldown (alert_pad_drive)
    );

endmodule

// File: rtl/thermal_alert_checker.sv
module thermal_alert_checker
    import thermal_alert_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             sample_valid,
    input logic             is_fault,
    input logic             below_rearm,
    input logic             cfg_interrupt,
    input logic             cfg_write,
    input logic             bus_read,
    input alert_state_e     state,
    input logic [CNT_W-1:0] fault_cnt,
    input logic             alert_active
);

    // R3: a pending count is never zero and never reaches the largest run.
    a_r3_qualify_count_range: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_QUALIFY) |-> (fault_cnt != '0 && fault_cnt < CNT_W'(MAX_FAULTS)));

    // R2: the alert only rises on an edge that captured a fault result.
    a_r2_rise_needs_fault: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alert_active) |-> $past(sample_valid && is_fault));

    // R4: a non-fault result ends a pending run.
    a_r4_nonfault_breaks: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_QUALIFY && sample_valid && !is_fault) |=> (state == ST_QUIET));

    // R5: comparator alert holds unless a below-re-arm result arrives.
    a_r5_cmp_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ALERT && !cfg_interrupt && !(sample_valid && below_rearm))
        |=> (state == ST_ALERT));

    // R6: an interrupt-mode read releases the alert.
    a_r6_int_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ALERT && cfg_interrupt && bus_read) |=> (state == ST_QUIET));

    // R8: idle cycles keep state and count.
    a_r8_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!sample_valid && !bus_read && !cfg_write) |=> ($stable(state) && $stable(fault_cnt)));

endmodule

bind thermal_alert_ctrl thermal_alert_checker u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .sample_valid  (sample_valid),
    .is_fault      (is_fault),
    .below_rearm   (below_rearm),
    .cfg_interrupt (cfg_interrupt),
    .cfg_write     (cfg_write),
    .bus_read      (bus_read),
    .state         (state),
    .fault_cnt     (fault_cnt),
    .alert_active  (alert_active)
);

// File: tb/thermal_alert_ctrl_test.sv
module thermal_alert_ctrl_test;

    localparam int CLK_P = 10;
    localparam logic [15:0] HOT  = 16'h5230;
    localparam logic [15:0] MID  = 16'h4D00;
    localparam logic [15:0] EQRA = 16'h4B00;
    localparam logic [15:0] COLD = 16'h1900;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        sample_valid;
    logic [15:0] sample_word;
    logic [15:0] trip_limit;
    logic [15:0] rearm_limit;
    logic        cfg_interrupt;
    logic        cfg_active_high;
    logic [1:0]  cfg_fault_sel;
    logic        cfg_write;
    logic        bus_read;
    logic        alert_pad_drive;

    int checks = 0;
    int fails  = 0;
    bit m_alert = 1'b0;
    int m_cnt   = 0;

    always #(CLK_P/2) clk = ~clk;

    thermal_alert_ctrl uut (
        .clk             (clk),
        .rst_n           (rst_n),
        .sample_valid    (sample_valid),
        .sample_word     (sample_word),
        .trip_limit      (trip_limit),
        .rearm_limit     (rearm_limit),
        .cfg_interrupt   (cfg_interrupt),
        .cfg_active_high (cfg_active_high),
        .cfg_fault_sel   (cfg_fault_sel),
        .cfg_write       (cfg_write),
        .bus_read        (bus_read),
        .alert_pad_drive (alert_pad_drive)
    );

    function automatic int need_of(input logic [1:0] s);
        return (s == 2'b11) ? 6 : (1 << s);
    endfunction

    task automatic check(input string tag, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: pad drive %0b, expected %0b (t=%0t)", tag, got, exp, $time);
        end
    endtask

    // One clock of stimulus, model update at the edge, check at the next negedge.
    task automatic step(input string tag, input bit v, input logic [15:0] t,
                        input bit r, input bit w);
        bit fault, below;
        sample_valid = v; sample_word = t; bus_read = r; cfg_write = w;
        @(posedge clk);
        fault = $signed(t[15:4]) >= $signed(trip_limit[15:4]);
        below = $signed(t[15:4]) <  $signed(rearm_limit[15:4]);
        if (m_alert) begin
            if (cfg_interrupt) begin
                if (r) begin m_alert = 1'b0; m_cnt = 0; end
            end else if (v && below) begin
                m_alert = 1'b0; m_cnt = 0;
            end
        end else if (w) begin
            m_cnt = 0;
        end else if (v) begin
            if (fault) begin
                m_cnt++;
                if (m_cnt >= need_of(cfg_fault_sel)) begin m_alert = 1'b1; m_cnt = 0; end
            end else begin
                m_cnt = 0;
            end
        end
        @(negedge clk);
        sample_valid = 1'b0; bus_read = 1'b0; cfg_write = 1'b0;
        check(tag, alert_pad_drive, m_alert ^ cfg_active_high);
    endtask

    initial begin
        #(CLK_P * 200000);
        fails++;
        $display("FAIL watchdog: run did not complete, actual hung, expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        sample_valid = 1'b0; sample_word = '0; bus_read = 1'b0; cfg_write = 1'b0;
        trip_limit = 16'h5000; rearm_limit = 16'h4B00;
        cfg_interrupt = 1'b0; cfg_fault_sel = 2'b00; cfg_active_high = 1'b0;
        #1;
        check("R1", alert_pad_drive, 1'b0);
        cfg_active_high = 1'b1;
        #1;
        check("R1", alert_pad_drive, 1'b1);
        cfg_active_high = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", alert_pad_drive, 1'b0);

        // Sweep over polarity, mode and run length.
        for (int pol = 0; pol < 2; pol++) begin
            for (int md = 0; md < 2; md++) begin
                for (int sel = 0; sel < 4; sel++) begin
                    int n;
                    cfg_active_high = pol[0];
                    cfg_interrupt   = md[0];
                    cfg_fault_sel   = sel[1:0];
                    n = need_of(cfg_fault_sel);
                    step("R9", 1'b0, '0, 1'b0, 1'b1);
                    step("R5", 1'b1, COLD, 1'b1, 1'b0);
                    // broken run must not trip
                    for (int i = 0; i < n - 1; i++) step("R3", 1'b1, HOT, 1'b0, 1'b0);
                    step("R4", 1'b1, MID, 1'b0, 1'b0);
                    for (int i = 0; i < n - 1; i++) step("R4", 1'b1, HOT, 1'b0, 1'b0);
                    // final fault with a coinciding read
                    step("R6", 1'b1, HOT, 1'b1, 1'b0);
                    repeat (3) step("R8", 1'b0, '0, 1'b0, 1'b0);
                    step("R6", 1'b0, '0, 1'b1, 1'b0);
                    step("R5", 1'b1, EQRA, 1'b0, 1'b0);
                    step("R11", 1'b0, '0, 1'b1, 1'b0);
                    step("R5", 1'b1, COLD, 1'b0, 1'b0);
                    // configuration write breaks a pending run
                    for (int i = 0; i < n - 1; i++) step("R9", 1'b1, HOT, 1'b0, 1'b0);
                    step("R9", 1'b1, HOT, 1'b0, 1'b1);
                    for (int i = 0; i < n - 1; i++) step("R9", 1'b1, HOT, 1'b0, 1'b0);
                    step("R7", 1'b1, HOT, 1'b0, 1'b0);
                    step("R9", 1'b0, '0, 1'b0, 1'b1);
                    step("R7", 1'b1, HOT, 1'b1, 1'b0);
                    for (int i = 0; i < n; i++) step("R7", 1'b1, HOT, 1'b0, 1'b0);
                    // live polarity flip
                    cfg_active_high = ~cfg_active_high;
                    #1;
                    check("R10", alert_pad_drive, m_alert ^ cfg_active_high);
                    cfg_active_high = ~cfg_active_high;
                    @(negedge clk);
                    check("R10", alert_pad_drive, m_alert ^ cfg_active_high);
                end
            end
        end

        // Limit boundaries, low-nibble junk and signed compare.
        cfg_active_high = 1'b0; cfg_interrupt = 1'b0; cfg_fault_sel = 2'b00;
        step("R2", 1'b1, COLD, 1'b1, 1'b1);
        step("R2", 1'b1, 16'h4FFF, 1'b0, 1'b0);
        step("R2", 1'b1, 16'h500F, 1'b0, 1'b0);
        step("R2", 1'b1, 16'h4B0F, 1'b0, 1'b0);
        step("R2", 1'b1, 16'h4AFF, 1'b0, 1'b0);
        trip_limit  = 16'hFF00;
        rearm_limit = 16'hFE00;
        step("R2", 1'b1, 16'h8000, 1'b0, 1'b0);
        step("R2", 1'b1, 16'h7FF0, 1'b0, 1'b0);
        step("R2", 1'b1, 16'hFE00, 1'b0, 1'b0);
        step("R2", 1'b1, 16'hFDF0, 1'b0, 1'b0);
        step("R2", 1'b1, 16'hFF00, 1'b0, 1'b0);
        step("R2", 1'b1, 16'h0000, 1'b0, 1'b0);
        step("R2", 1'b1, 16'h8000, 1'b0, 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule